// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB panel. It drives the horizontal sync, the vertical sync, the data enable and a pixel clock enable. Two region state machines make the timing. One steps through the regions of a line and the other steps through the regions of a frame. Each region is SYNC, BACK, ACTIVE or FRONT, and the machines visit them in that order. A transition SYNC→BACK→ACTIVE→FRONT→SYNC is taken when the region's counter reaches its programmed length. The horizontal machine advances on every pixel clock enable. The vertical machine advances only when the horizontal machine leaves FRONT. A frame wrap is the vertical machine leaving FRONT while the horizontal machine does the same.

Software programs the block through a simple write port. It sets every region length as the count minus one, a pixel clock divider with a bypass, sync polarities, two output enables and a frame interrupt. The sync, porch and size fields and the frame-synchronised enable go into shadow registers. They are copied to the working set only at a frame wrap. That way a half-written timing set never reaches the panel. The frame interrupt latches into a pending bit that is cleared by writing one. The irq output carries the pending bit only while both interrupt enables are set.

Top module: `lcd_raster_gen`

## Requirements
- R1: After reset hsync, vsync, de and irq are all 0, and pix_ce is 1 on every cycle (divider bypassed).
- R2: Each line lasts (hsync_m1+1)+(hback_m1+1)+(width_m1+1)+(hfront_m1+1) pixel clocks, starting with hsync active for hsync_m1+1 pixels. Register 2 holds hsync_m1 in [7:0], hback_m1 in [15:8] and hfront_m1 in [23:16]. Register 4 holds width_m1 in [11:0].
- R3: Each frame lasts (vsync_m1+1)+(vback_m1+1)+(height_m1+1)+(vfront_m1+1) lines, starting with vsync active for vsync_m1+1 lines. Register 3 holds vsync_m1 in [7:0], vback_m1 in [15:8] and vfront_m1 in [23:16]. Register 4 holds height_m1 in [27:16].
- R4: de is active only while both the line and the frame are in their ACTIVE region, and never together with either sync.
- R5: In control register 0, bit 2 selects the divider and bits [15:8] hold ratio minus one. With bit 2 set, pix_ce pulses once every ratio_m1+1 cycles. With bit 2 clear, pix_ce is high every cycle whatever the ratio field holds.
- R6: The outputs drive their active levels only when control bit 0 (immediate enable) and the working frame enable are both 1. The working frame enable is loaded from control bit 1 only at a frame wrap, so outputs first become active at the start of a frame.
- R7: A timing write made during a frame leaves that frame's length unchanged and applies from the next frame.
- R8: Register 1 inverts the sync and enable outputs: bit 0 inverts hsync, bit 1 vsync and bit 2 de. The change takes effect on the next cycle, including while the outputs are disabled.
- R9: The selected frame event sets a pending bit whatever the enables are. irq (register 5: bit 0 frame interrupt enable, bit 1 global enable) is high only while pending is set and both enables are 1.
- R10: Writing register 6 with bit 0 set clears pending. Writing it with bit 0 clear does nothing. A new event in the same cycle wins over the clear.
- R11: Register 5 bits [5:4] choose the event: 0 = frame wrap (vsync start), 1 = frame enters ACTIVE, 2 = frame enters FRONT, 3 = none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 32 | Register write data |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| irq | output | 1 | Masked frame interrupt |

## Verification
A region machine left in a wrong state or with a wrong count shows up within one line as a wrong hsync width or a misplaced de pulse. The bench compares these pixel by pixel against a frame it builds itself from the programmed counts. A working timing or enable copied at the wrong moment changes a frame's length. The bench catches this by counting pixels between vsync rises across a mid-frame rewrite. A pending bit that sets, clears or masks wrongly is seen on irq within one frame. The bench measures where irq rises relative to vsync and de for each event choice.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    typedef enum logic [1:0] {RG_SYNC, RG_BACK, RG_ACTIVE, RG_FRONT} region_e;

    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] ADDR_CTRL     = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_POL      = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_HTIM     = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_VTIM     = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_SIZE     = 3'd4;
    localparam logic [REG_AW-1:0] ADDR_IRQ_CFG  = 3'd5;
    localparam logic [REG_AW-1:0] ADDR_IRQ_STAT = 3'd6;
endpackage

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          use_div,
    input  logic [DW-1:0] ratio_m1,
    output logic          ce
);
    logic [DW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt >= ratio_m1);
    assign ce     = !use_div || at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!use_div || at_end) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis import lcdt_pkg::*; #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [CW-1:0] sync_m1,
    input  logic [CW-1:0] back_m1,
    input  logic [CW-1:0] act_m1,
    input  logic [CW-1:0] front_m1,
    output region_e       region,
    output logic          last
);
    region_e       nxt;
    logic [CW-1:0] cur_len;
    logic [CW-1:0] cnt;

    always_comb begin
        unique case (region)
            RG_SYNC:   begin cur_len = sync_m1;  nxt = RG_BACK;   end
            RG_BACK:   begin cur_len = back_m1;  nxt = RG_ACTIVE; end
            RG_ACTIVE: begin cur_len = act_m1;   nxt = RG_FRONT;  end
            RG_FRONT:  begin cur_len = front_m1; nxt = RG_SYNC;   end
            default:   begin cur_len = '0;       nxt = RG_SYNC;   end
        endcase
    end

    assign last = step && (cnt >= cur_len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            region <= RG_SYNC;
            cnt    <= '0;
        end else if (last) begin
            region <= nxt;
            cnt    <= '0;
        end else if (step) begin
            cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lcdt_regs.sv
module lcdt_regs import lcdt_pkg::*; #(
    parameter int PW = 8,
    parameter int SW = 12,
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              frame_wrap,
    output logic              out_en,
    output logic              run_f,
    output logic              div_use,
    output logic [DW-1:0]     div_m1,
    output logic [2:0]        pol,
    output logic [SW-1:0]     h_sync_m1, h_back_m1, h_act_m1, h_front_m1,
    output logic [SW-1:0]     v_sync_m1, v_back_m1, v_act_m1, v_front_m1,
    output logic              irq_fen,
    output logic              irq_gen,
    output logic [1:0]        irq_sel,
    output logic              clr_pend
);
    logic [PW-1:0] sh_hs, sh_hb, sh_hf, sh_vs, sh_vb, sh_vf;
    logic [SW-1:0] sh_w, sh_h;
    logic          sh_run;
    logic          unused_wr;

    assign unused_wr = ^wr_data;
    assign clr_pend  = wr_en && (wr_addr == ADDR_IRQ_STAT) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_en <= 1'b0; sh_run <= 1'b0; div_use <= 1'b0; div_m1 <= '0;
            pol <= '0; irq_fen <= 1'b0; irq_gen <= 1'b0; irq_sel <= '0;
            sh_hs <= '0; sh_hb <= '0; sh_hf <= '0;
            sh_vs <= '0; sh_vb <= '0; sh_vf <= '0;
            sh_w <= '0; sh_h <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: begin
                    out_en  <= wr_data[0];
                    sh_run  <= wr_data[1];
                    div_use <= wr_data[2];
                    div_m1  <= wr_data[8 +: DW];
                end
                ADDR_POL:  pol <= wr_data[2:0];
                ADDR_HTIM: begin
                    sh_hs <= wr_data[0 +: PW];
                    sh_hb <= wr_data[PW +: PW];
                    sh_hf <= wr_data[2*PW +: PW];
                end
                ADDR_VTIM: begin
                    sh_vs <= wr_data[0 +: PW];
                    sh_vb <= wr_data[PW +: PW];
                    sh_vf <= wr_data[2*PW +: PW];
                end
                ADDR_SIZE: begin
                    sh_w <= wr_data[0 +: SW];
                    sh_h <= wr_data[16 +: SW];
                end
                ADDR_IRQ_CFG: begin
                    irq_fen <= wr_data[0];
                    irq_gen <= wr_data[1];
                    irq_sel <= wr_data[5:4];
                end
                default: ;
            endcase
        end
    end

    // working set, loaded only at a frame wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_f <= 1'b0;
            h_sync_m1 <= '0; h_back_m1 <= '0; h_act_m1 <= '0; h_front_m1 <= '0;
            v_sync_m1 <= '0; v_back_m1 <= '0; v_act_m1 <= '0; v_front_m1 <= '0;
        end else if (frame_wrap) begin
            run_f      <= sh_run;
            h_sync_m1  <= SW'(sh_hs);
            h_back_m1  <= SW'(sh_hb);
            h_act_m1   <= sh_w;
            h_front_m1 <= SW'(sh_hf);
            v_sync_m1  <= SW'(sh_vs);
            v_back_m1  <= SW'(sh_vb);
            v_act_m1   <= sh_h;
            v_front_m1 <= SW'(sh_vf);
        end
    end
endmodule

// File: rtl/lcdt_irq.sv
module lcdt_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_vs,
    input  logic       ev_act,
    input  logic       ev_fp,
    input  logic [1:0] sel,
    input  logic       clr,
    input  logic       fen,
    input  logic       gen,
    output logic       pend,
    output logic       irq
);
    logic ev;

    always_comb begin
        unique case (sel)
            2'd0:    ev = ev_vs;
            2'd1:    ev = ev_act;
            2'd2:    ev = ev_fp;
            default: ev = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pend <= 1'b0;
        else if (ev)  pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end

    assign irq = pend && fen && gen;
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen import lcdt_pkg::*; #(
    parameter int PW = 8,
    parameter int SW = 12,
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic        pix_ce,
    output logic        hsync,
    output logic        vsync,
    output logic        de,
    output logic        irq
);
    logic          out_en, run_f, div_use, irq_fen, irq_gen, clr_pend, pend;
    logic [DW-1:0] div_m1;
    logic [2:0]    pol;
    logic [1:0]    irq_sel;
    logic [SW-1:0] h_sync_m1, h_back_m1, h_act_m1, h_front_m1;
    logic [SW-1:0] v_sync_m1, v_back_m1, v_act_m1, v_front_m1;
    region_e       h_region, v_region;
    logic          h_last, v_last, h_wrap, frame_wrap;
    logic          vis, hs_raw, vs_raw, de_raw;

    lcdt_regs #(.PW(PW), .SW(SW), .DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_wrap(frame_wrap),
        .out_en(out_en), .run_f(run_f), .div_use(div_use), .div_m1(div_m1),
        .pol(pol),
        .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1),
        .h_act_m1(h_act_m1), .h_front_m1(h_front_m1),
        .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1),
        .v_act_m1(v_act_m1), .v_front_m1(v_front_m1),
        .irq_fen(irq_fen), .irq_gen(irq_gen), .irq_sel(irq_sel),
        .clr_pend(clr_pend)
    );

    lcdt_pixdiv #(.DW(DW)) div_i (
        .clk(clk), .rst_n(rst_n), .use_div(div_use), .ratio_m1(div_m1),
        .ce(pix_ce)
    );

    lcdt_axis #(.CW(SW)) h_axis_i (
        .clk(clk), .rst_n(rst_n), .step(pix_ce),
        .sync_m1(h_sync_m1), .back_m1(h_back_m1),
        .act_m1(h_act_m1), .front_m1(h_front_m1),
        .region(h_region), .last(h_last)
    );

    assign h_wrap = h_last && (h_region == RG_FRONT);

    lcdt_axis #(.CW(SW)) v_axis_i (
        .clk(clk), .rst_n(rst_n), .step(h_wrap),
        .sync_m1(v_sync_m1), .back_m1(v_back_m1),
        .act_m1(v_act_m1), .front_m1(v_front_m1),
        .region(v_region), .last(v_last)
    );

    assign frame_wrap = v_last && (v_region == RG_FRONT);

    lcdt_irq irq_i (
        .clk(clk), .rst_n(rst_n),
        .ev_vs(frame_wrap),
        .ev_act(v_last && (v_region == RG_BACK)),
        .ev_fp(v_last && (v_region == RG_ACTIVE)),
        .sel(irq_sel), .clr(clr_pend), .fen(irq_fen), .gen(irq_gen),
        .pend(pend), .irq(irq)
    );

    assign vis    = out_en && run_f;
    assign hs_raw = vis && (h_region == RG_SYNC);
    assign vs_raw = vis && (v_region == RG_SYNC);
    assign de_raw = vis && (h_region == RG_ACTIVE) && (v_region == RG_ACTIVE);

    assign hsync = hs_raw ^ pol[0];
    assign vsync = vs_raw ^ pol[1];
    assign de    = de_raw ^ pol[2];
endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker #(
    parameter int SW = 12,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_wrap,
    input logic          run_f,
    input logic [SW-1:0] h_act_m1,
    input logic          hs_raw,
    input logic          vs_raw,
    input logic          de_raw,
    input logic          pix_ce,
    input logic          div_use,
    input logic [DW-1:0] div_m1,
    input logic [1:0]    irq_sel,
    input logic          irq_fen,
    input logic          irq_gen,
    input logic          clr_pend,
    input logic          pend,
    input logic          irq
);
    a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> (!hs_raw && !vs_raw));

    a_r5_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ce && div_use && div_m1 != '0) |=> (!pix_ce || !div_use || div_m1 == '0));

    a_r6_run_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> $stable(run_f));

    a_r7_timing_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> $stable(h_act_m1));

    a_r9_vs_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel == 2'd0 && frame_wrap && irq_fen && irq_gen) |=> irq);

    a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel == 2'd3 && clr_pend) |=> !pend);

    a_r11_none_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel == 2'd3 && !pend) |=> !pend);
endmodule

bind lcd_raster_gen lcdt_checker #(.SW(SW), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_wrap(frame_wrap), .run_f(run_f),
    .h_act_m1(h_act_m1), .hs_raw(hs_raw), .vs_raw(vs_raw), .de_raw(de_raw),
    .pix_ce(pix_ce), .div_use(div_use), .div_m1(div_m1),
    .irq_sel(irq_sel), .irq_fen(irq_fen), .irq_gen(irq_gen),
    .clr_pend(clr_pend), .pend(pend), .irq(irq)
);

// File: tb/lcd_raster_gen_tb_top.sv
module lcd_raster_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pix_ce, hsync, vsync, de, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int ce_cnt = 0;

    logic [2:0] exp_q[$];   // {hs, vs, de}
    bit   mon_on = 0;
    logic mon_prev_vs = 1'b0;

    always #5 clk = ~clk;

    lcd_raster_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
        .de(de), .irq(irq)
    );

    always @(posedge clk) if (pix_ce) ce_cnt <= ce_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: expected pixel stream of one frame from the requirement counts
    task automatic push_frame(input int hs, input int hb, input int w, input int hf,
                              input int vs, input int vb, input int h, input int vf);
        for (int v = 0; v < vs + vb + h + vf; v++) begin
            for (int x = 0; x < hs + hb + w + hf; x++) begin
                logic e_hs, e_vs, e_de;
                e_hs = (x < hs);
                e_vs = (v < vs);
                e_de = (x >= hs + hb) && (x < hs + hb + w) &&
                       (v >= vs + vb) && (v < vs + vb + h);
                exp_q.push_back({e_hs, e_vs, e_de});
            end
        end
    endtask

    // monitor: starts at a vsync rise, compares one item per pixel
    always @(negedge clk) begin
        if (!mon_on && exp_q.size() > 0 && vsync && !mon_prev_vs) mon_on = 1;
        if (mon_on && pix_ce && exp_q.size() > 0) begin
            logic [2:0] e;
            e = exp_q.pop_front();
            check(hsync == e[2], "R2 hsync", int'(hsync), int'(e[2]));
            check(vsync == e[1], "R3 vsync", int'(vsync), int'(e[1]));
            check(de == e[0],    "R4 de",    int'(de),    int'(e[0]));
        end
        if (exp_q.size() == 0) mon_on = 0;
        mon_prev_vs = vsync;
    end

    task automatic wait_vs_rise();
        logic p;
        p = vsync;
        forever begin
            @(negedge clk);
            if (vsync && !p) break;
            p = vsync;
        end
    endtask

    task automatic quiet(input int cycles, input string req);
        bit seen;
        seen = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (hsync || vsync || de) seen = 1;
        end
        check(!seen, req, int'(seen), 0);
    endtask

    task automatic ce_period(output int p);
        while (!pix_ce) @(negedge clk);
        p = 0;
        do begin @(negedge clk); p++; end while (!pix_ce);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p, b1, b2, b3, n;
        logic pv;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!hsync && !vsync && !de, "R1 syncs idle", {hsync, vsync, de}, 0);
        check(!irq, "R1 irq idle", irq, 0);
        check(pix_ce, "R1 pix_ce every cycle", pix_ce, 1);

        // R8 polarity applies while disabled
        wr(3'd1, 32'h7);
        check({hsync, vsync, de} == 3'b111, "R8 inverted idle", {hsync, vsync, de}, 7);
        wr(3'd1, 32'h0);
        check({hsync, vsync, de} == 3'b000, "R8 normal idle", {hsync, vsync, de}, 0);

        // R5 divider
        wr(3'd0, 32'h0000_0204);
        ce_period(p); check(p == 3, "R5 ratio 3", p, 3);
        ce_period(p); check(p == 3, "R5 ratio 3 again", p, 3);
        wr(3'd0, 32'h0000_0004);
        ce_period(p); check(p == 1, "R5 ratio 1", p, 1);
        wr(3'd0, 32'h0000_0500);
        ce_period(p); check(p == 1, "R5 bypass ignores ratio", p, 1);

        // timing A, immediate enable only: R6 nothing shows
        wr(3'd2, 32'h0001_0201);
        wr(3'd3, 32'h0001_0100);
        wr(3'd4, 32'h0002_0004);
        wr(3'd0, 32'h0000_0205);
        quiet(400, "R6 no output without frame enable");

        // R6 frame enable: scoreboard frame A (R2 R3 R4), starts at frame start
        wr(3'd0, 32'h0000_0207);
        push_frame(2, 3, 5, 2, 1, 2, 3, 2);
        while (exp_q.size() > 0) @(negedge clk);

        // R7 mid-frame rewrite to timing B
        wait_vs_rise(); b1 = ce_cnt;
        wr(3'd2, 32'h0000_0000);
        wr(3'd3, 32'h0000_0001);
        wr(3'd4, 32'h0001_0003);
        wait_vs_rise(); b2 = ce_cnt;
        wait_vs_rise(); b3 = ce_cnt;
        check(b2 - b1 == 96, "R7 current frame keeps old timing", b2 - b1, 96);
        check(b3 - b2 == 42, "R7 next frame uses new timing", b3 - b2, 42);

        // bypass divider, scoreboard frame B (R2 R3 R4)
        wr(3'd0, 32'h0000_0003);
        push_frame(1, 1, 4, 1, 2, 1, 2, 1);
        while (exp_q.size() > 0) @(negedge clk);

        // R6 immediate enable off
        wr(3'd0, 32'h0000_0002);
        quiet(100, "R6 immediate enable gates outputs");
        wr(3'd0, 32'h0000_0003);

        // R9 masked pending
        wr(3'd5, 32'h0000_0001);
        seen = 0;
        repeat (100) begin @(negedge clk); if (irq) seen = 1; end
        check(!seen, "R9 masked by global enable", int'(seen), 0);
        wr(3'd5, 32'h0000_0003);
        check(irq, "R9 latched pending appears", irq, 1);
        wr(3'd6, 32'h0000_0000);
        check(irq, "R10 write 0 keeps pending", irq, 1);
        wait_vs_rise();
        wr(3'd6, 32'h0000_0001);
        check(!irq, "R10 write 1 clears", irq, 0);

        // R11 source 0: irq rises with vsync
        pv = vsync;
        forever begin @(negedge clk); if (irq) break; pv = vsync; end
        check(vsync && !pv, "R11 vsync source aligns with vsync rise", {vsync, pv}, 2);

        // R11 source 1: irq rises at frame ACTIVE entry, de follows 2 pixels later
        wr(3'd5, 32'h0000_0013);
        wait_vs_rise();
        wr(3'd6, 32'h0000_0001);
        while (!irq) @(negedge clk);
        n = 0;
        while (!de) begin @(negedge clk); n++; end
        check(n == 2, "R11 active source leads de by h sync+back", n, 2);

        // R11 source 3: none
        wr(3'd5, 32'h0000_0033);
        wr(3'd6, 32'h0000_0001);
        seen = 0;
        repeat (150) begin @(negedge clk); if (irq) seen = 1; end
        check(!seen, "R11 no source never sets", int'(seen), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule